// File: doc/BRIEF.md
# Transmit Queue Hang Detector

This block decides whether the transmit queue machinery of a DMA engine is stuck in one of two known deadlock patterns. It watches four 32-bit debug status words, which it samples once per clock. A check begins with a single-cycle request. The block then captures the four words and confirms that the live words stay equal to the captured copy for a fixed run of further samples. If any word moves during that run, the engine is still making progress and the check reports no hang.

When the words stay frozen for the whole run, the captured copy is compared against two signatures built from packed sub-state fields. The first signature is looked for before the second. A frozen state that matches neither is reported as an unknown hang. The result is a two-bit code, and a one-cycle completion pulse marks when it is valid. A busy flag covers the stability run, and a new request is accepted only when the block is idle.

Top module: `txq_hang_detector`

## Requirements
- R1: After synchronous reset, `busy` and `done` are low and `result` is 0.
- R2: A `start` seen while idle captures all four words and raises `busy` on the next cycle. `busy` stays high until the check completes and falls only in the cycle in which `done` pulses.
- R3: A `start` seen while `busy` is high is ignored: the capture and the completion time are unchanged.
- R4: If any word differs from its captured value at any of the sampled cycles after capture, the check ends one cycle after that sample with `result` = 0 (no hang). A mismatch at the first sample gives a busy run of 1 cycle, and a mismatch at the last sample gives a run of RUN_LEN cycles.
- R5: If all four words equal the captured values for RUN_LEN (default 50) consecutive samples after capture, `done` pulses one cycle after the last sample. `busy` has then been high for exactly RUN_LEN cycles.
- R6: The chain field holds 5-bit slots. `chain_a_i` carries six slots at bits 5i+4:5i for i=0..5, and `chain_b_i` carries four slots at the same positions for i=0..3. The field matches a target when any of these ten slots equals it. Bits of `chain_b_i` above slot 3 are never examined.
- R7: Signature 1 (code 1) requires a chain slot equal to 0x6 and `cmpl_i[1:0]` = 0x1.
- R8: Signature 2 (code 2) requires all three of `qstat_i[21:18]` = 0x9, `qstat_i[25:22]` = 0x8 and `qstat_i[28:26]` = 0x4.
- R9: When the frozen words satisfy both signatures, the result is code 1.
- R10: Frozen words that fully satisfy neither signature report code 3 (unknown). A signature with one field wrong does not match.
- R11: `done` is high for exactly one cycle per check. `result` is 2 bits (0 none, 1 signature 1, 2 signature 2, 3 unknown) and holds its value until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a hang check (accepted when idle) |
| qstat_i | input | 32 | Queue status word: stitch, fetch and completion sub-states |
| chain_a_i | input | 32 | Chain state word, six 5-bit slots |
| chain_b_i | input | 32 | Chain state word, four 5-bit slots |
| cmpl_i | input | 32 | Channel completion word, state in bits 1:0 |
| busy | output | 1 | High during the stability run |
| done | output | 1 | One-cycle pulse when `result` is updated |
| result | output | 2 | 0 none, 1 signature 1, 2 signature 2, 3 unknown |

## Verification
The words are held frozen with a chain value of 6 placed in the top slot of the six-slot word and, separately, in the last valid slot of the four-slot word. A further case places the value 6 in the unexamined fifth position of the four-slot word, which shows whether slot indexing and slot count are right. Signature 1, signature 2, both at once, all-zero words and signatures with a single wrong field are each frozen. Together these cases check the precedence order, the requirement that every field of a signature match, and the unknown fallback. Words that move at the first or the last sample, and start pulses during a run, probe the edges of the stability window and the idle-only acceptance.

// File: rtl/txq_hang_pkg.sv
package txq_hang_pkg;

  typedef enum logic [1:0] {
    HANG_NONE    = 2'd0,
    HANG_SIG1    = 2'd1,
    HANG_SIG2    = 2'd2,
    HANG_UNKNOWN = 2'd3
  } hang_code_e;

  // Chain slot geometry
  localparam int CHAIN_SLOT_W  = 5;
  localparam int CHAIN_SLOTS_A = 6;
  localparam int CHAIN_SLOTS_B = 4;

  // Queue status word field positions
  localparam int STITCH_LSB = 18;
  localparam int STITCH_W   = 4;
  localparam int FETCH_LSB  = 22;
  localparam int FETCH_W    = 4;
  localparam int QDONE_LSB  = 26;
  localparam int QDONE_W    = 3;

  // Channel completion field
  localparam int CDONE_LSB = 0;
  localparam int CDONE_W   = 2;

  // Signature targets
  localparam logic [CHAIN_SLOT_W-1:0] SIG1_CHAIN  = 5'h06;
  localparam logic [CDONE_W-1:0]      SIG1_CDONE  = 2'h1;
  localparam logic [STITCH_W-1:0]     SIG2_STITCH = 4'h9;
  localparam logic [FETCH_W-1:0]      SIG2_FETCH  = 4'h8;
  localparam logic [QDONE_W-1:0]      SIG2_QDONE  = 3'h4;

endpackage

// File: rtl/txq_chain_scan.sv
module txq_chain_scan #(
  parameter int WORD_W = 32,
  parameter int SLOT_W = 5,
  parameter int SLOTS  = 6
) (
  input  logic [WORD_W-1:0] word,
  input  logic [SLOT_W-1:0] target,
  output logic              hit
);

  localparam int USED_W = SLOT_W * SLOTS;

  logic [SLOTS-1:0] slot_eq;

  generate
    if (USED_W > WORD_W) begin : g_bad_geom
      initial $error("txq_chain_scan: slots exceed word width");
    end
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      assign slot_eq[s] = (word[s*SLOT_W +: SLOT_W] == target);
    end
  endgenerate

  assign hit = |slot_eq;

endmodule

// File: rtl/txq_sig_match.sv
module txq_sig_match
  import txq_hang_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] qstat,
  input  logic [WORD_W-1:0] chain_a,
  input  logic [WORD_W-1:0] chain_b,
  input  logic [WORD_W-1:0] cmpl,
  output hang_code_e        code
);

  logic hit_a, hit_b;
  logic sig1, sig2;

  txq_chain_scan #(
    .WORD_W (WORD_W),
    .SLOT_W (CHAIN_SLOT_W),
    .SLOTS  (CHAIN_SLOTS_A)
  ) scan_a_i (
    .word   (chain_a),
    .target (SIG1_CHAIN),
    .hit    (hit_a)
  );

  txq_chain_scan #(
    .WORD_W (WORD_W),
    .SLOT_W (CHAIN_SLOT_W),
    .SLOTS  (CHAIN_SLOTS_B)
  ) scan_b_i (
    .word   (chain_b),
    .target (SIG1_CHAIN),
    .hit    (hit_b)
  );

  always_comb begin
    sig1 = (hit_a || hit_b) &&
           (cmpl[CDONE_LSB +: CDONE_W] == SIG1_CDONE);
    sig2 = (qstat[STITCH_LSB +: STITCH_W] == SIG2_STITCH) &&
           (qstat[FETCH_LSB  +: FETCH_W]  == SIG2_FETCH)  &&
           (qstat[QDONE_LSB  +: QDONE_W]  == SIG2_QDONE);
    if (sig1)      code = HANG_SIG1;
    else if (sig2) code = HANG_SIG2;
    else           code = HANG_UNKNOWN;
  end

endmodule

// File: rtl/txq_freeze_seq.sv
module txq_freeze_seq #(
  parameter int WORD_W  = 32,
  parameter int WORDS   = 4,
  parameter int RUN_LEN = 50
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  input  logic [WORDS-1:0][WORD_W-1:0] live,
  output logic [WORDS-1:0][WORD_W-1:0] held,
  output logic                         busy,
  output logic                         finish,
  output logic                         frozen
);

  localparam int CNT_W = (RUN_LEN < 2) ? 1 : $clog2(RUN_LEN);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);

  logic [CNT_W-1:0] cnt;
  logic [WORDS-1:0] diff;

  generate
    for (genvar w = 0; w < WORDS; w++) begin : g_cmp
      assign diff[w] = (live[w] != held[w]);
    end
  endgenerate

  always_comb begin
    frozen = ~|diff;
    finish = busy && (!frozen || (cnt == LAST));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      held <= '0;
    end else if (!busy) begin
      if (start) begin
        held <= live;
        busy <= 1'b1;
        cnt  <= '0;
      end
    end else if (finish) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/txq_hang_detector.sv
module txq_hang_detector
  import txq_hang_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int RUN_LEN = 50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] qstat_i,
  input  logic [WORD_W-1:0] chain_a_i,
  input  logic [WORD_W-1:0] chain_b_i,
  input  logic [WORD_W-1:0] cmpl_i,
  output logic              busy,
  output logic              done,
  output logic [1:0]        result
);

  localparam int WORDS = 4;

  logic [WORDS-1:0][WORD_W-1:0] live;
  logic [WORDS-1:0][WORD_W-1:0] held;
  logic                         finish;
  logic                         frozen;
  hang_code_e                   code;

  always_comb begin
    live[0] = qstat_i;
    live[1] = chain_a_i;
    live[2] = chain_b_i;
    live[3] = cmpl_i;
  end

  txq_freeze_seq #(
    .WORD_W  (WORD_W),
    .WORDS   (WORDS),
    .RUN_LEN (RUN_LEN)
  ) seq_i (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .live   (live),
    .held   (held),
    .busy   (busy),
    .finish (finish),
    .frozen (frozen)
  );

  txq_sig_match #(
    .WORD_W (WORD_W)
  ) match_i (
    .qstat   (held[0]),
    .chain_a (held[1]),
    .chain_b (held[2]),
    .cmpl    (held[3]),
    .code    (code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done   <= 1'b0;
      result <= HANG_NONE;
    end else begin
      done <= finish;
      if (finish) result <= frozen ? code : HANG_NONE;
    end
  end

endmodule

// File: rtl/txq_hang_chk.sv
module txq_hang_chk #(
  parameter int RUN_LEN = 50
) (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic [1:0] result
);

  int run_cnt;

  always_ff @(posedge clk) begin
    if (rst)       run_cnt <= 0;
    else if (busy) run_cnt <= run_cnt + 1;
    else           run_cnt <= 0;
  end

  a_r1_idle_after_reset: assert property (@(posedge clk)
    $fell(rst) |-> (!busy && !done && result == 2'd0));

  a_r2_start_raises_busy: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  a_r2_busy_ends_with_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  a_r5_done_when_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r5_full_run_for_hang: assert property (@(posedge clk) disable iff (rst)
    (done && result != 2'd0) |-> (run_cnt == RUN_LEN));

  a_r4_run_bounded: assert property (@(posedge clk) disable iff (rst)
    done |-> (run_cnt >= 1 && run_cnt <= RUN_LEN));

  a_r11_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r11_result_held: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));

endmodule

bind txq_hang_detector txq_hang_chk #(.RUN_LEN(RUN_LEN)) chk_i (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .result (result)
);

// File: tb/txq_hang_detector_tb_top.sv
module txq_hang_detector_tb_top;

  localparam int RUN = 50;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] w_q = '0, w_a = '0, w_b = '0, w_c = '0;
  logic        busy, done;
  logic [1:0]  result;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  txq_hang_detector #(.WORD_W(32), .RUN_LEN(RUN)) dut_i (
    .clk(clk), .rst(rst), .start(start),
    .qstat_i(w_q), .chain_a_i(w_a), .chain_b_i(w_b), .cmpl_i(w_c),
    .busy(busy), .done(done), .result(result)
  );

  // ---------------- reference model ----------------
  function automatic logic [1:0] classify(input logic [31:0] q, a, b, c);
    bit ch = 0;
    for (int i = 0; i < 6; i++) if (((a >> (5*i)) & 32'h1f) == 32'd6) ch = 1;
    for (int i = 0; i < 4; i++) if (((b >> (5*i)) & 32'h1f) == 32'd6) ch = 1;
    if (ch && ((c & 32'h3) == 32'd1)) return 2'd1;
    if ((((q >> 18) & 32'hf) == 32'd9) && (((q >> 22) & 32'hf) == 32'd8) &&
        (((q >> 26) & 32'h7) == 32'd4)) return 2'd2;
    return 2'd3;
  endfunction

  bit          m_busy, m_done;
  logic [1:0]  m_res;
  int          m_seen;
  logic [31:0] snap [4];

  always @(posedge clk) begin
    if (rst) begin
      m_busy <= 0; m_done <= 0; m_res <= 0; m_seen <= 0;
    end else begin
      m_done <= 0;
      if (!m_busy) begin
        if (start) begin
          snap[0] <= w_q; snap[1] <= w_a; snap[2] <= w_b; snap[3] <= w_c;
          m_busy <= 1; m_seen <= 0;
        end
      end else if (w_q != snap[0] || w_a != snap[1] || w_b != snap[2] || w_c != snap[3]) begin
        m_busy <= 0; m_done <= 1; m_res <= 2'd0;
      end else if (m_seen + 1 == RUN) begin
        m_busy <= 0; m_done <= 1; m_res <= classify(snap[0], snap[1], snap[2], snap[3]);
      end else begin
        m_seen <= m_seen + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R11: cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      check(busy == m_busy, "R2 busy vs model", int'(busy), int'(m_busy));
      check(done == m_done, "R11 done vs model", int'(done), int'(m_done));
      check(result == m_res, "R11 result vs model", int'(result), int'(m_res));
    end
  end

  task automatic finish_run();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      check(0, "watchdog", cycles, 150000);
      finish_run();
    end
  end

  // flip_at: sample index (1..RUN) at which chain_a_i changes, 0 for none
  // restart_at: cycle of the run at which start is pulsed again, 0 for none
  task automatic run_case(input logic [31:0] q, a, b, c, input int flip_at,
                          input int restart_at, input logic [1:0] exp,
                          input int exp_busy, input string req);
    int n = 0;
    int busy_n = 0;
    @(negedge clk);
    w_q = q; w_a = a; w_b = b; w_c = c; start = 1;
    @(negedge clk);
    start = 0;
    while (!done && n < 200) begin
      if (busy) busy_n++;
      start = (restart_at != 0 && n + 1 == restart_at);
      if (flip_at != 0 && n + 1 == flip_at) w_a = ~w_a;
      @(negedge clk);
      n++;
    end
    start = 0;
    check(done, {req, " done seen"}, int'(done), 1);
    check(result == exp, {req, " result"}, int'(result), int'(exp));
    check(busy_n == exp_busy, {req, " busy cycles"}, busy_n, exp_busy);
    @(negedge clk);
    check(!done && result == exp, {req, " R11 hold"}, int'(result), int'(exp));
    repeat (2) @(negedge clk);
  endtask

  localparam logic [31:0] SIG2_Q = (32'd9 << 18) | (32'd8 << 22) | (32'd4 << 26);

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(!busy && !done && result == 2'd0, "R1 reset state", int'(result), 0);

    // R6 R7: chain 6 in top slot of chain_a_i
    run_case(32'h0, 32'd6 << 25, 32'h0, 32'h1, 0, 0, 2'd1, RUN, "R7 sig1 slot a5");
    // R6: chain 6 in last valid slot of chain_b_i
    run_case(32'h0, 32'h0, 32'd6 << 15, 32'h1, 0, 0, 2'd1, RUN, "R6 sig1 slot b3");
    // R6: position beyond slot 3 of chain_b_i is not examined
    run_case(32'h0, 32'h0, 32'd6 << 20, 32'h1, 0, 0, 2'd3, RUN, "R6 unscanned slot");
    // R8
    run_case(SIG2_Q, 32'h0, 32'h0, 32'h0, 0, 0, 2'd2, RUN, "R8 sig2");
    // R9 both match
    run_case(SIG2_Q, 32'd6, 32'h0, 32'h1, 0, 0, 2'd1, RUN, "R9 precedence");
    // R10 unknown
    run_case(32'h0, 32'h0, 32'h0, 32'h0, 0, 0, 2'd3, RUN, "R10 all zero");
    run_case(32'h0, 32'd6 << 10, 32'h0, 32'h2, 0, 0, 2'd3, RUN, "R10 sig1 cmpl wrong");
    run_case(SIG2_Q ^ (32'd1 << 22), 32'h0, 32'h0, 32'h0, 0, 0, 2'd3, RUN, "R10 sig2 fetch wrong");
    // R4 mismatch at first and last sample
    run_case(32'h0, 32'd6, 32'h0, 32'h1, 1, 0, 2'd0, 1, "R4 move first");
    run_case(32'h0, 32'd6, 32'h0, 32'h1, RUN, 0, 2'd0, RUN, "R4 move last");
    // R5 exact run length, R3 start during run ignored
    run_case(SIG2_Q, 32'h0, 32'h0, 32'h0, 0, 20, 2'd2, RUN, "R3 restart ignored");
    run_case(32'h0, 32'd6, 32'h0, 32'h1, 0, 0, 2'd1, RUN, "R5 full run");

    finish_run();
  end

endmodule